// File: doc/BRIEF.md
# Sector Transfer Engine with Check Sum

This block carries one record between a host that moves 32-bit words and a storage stream that moves one byte per byte time. The record is split into fixed-length sectors. The last four byte positions of every sector hold a 32-bit check sum, and the rest of the sector holds data. The storage side paces the transfer. A `byte_tick` strobe marks each byte time, and the engine writes or reads exactly one byte at each tick while it is busy.

There are four orders. Write (0x01) unpacks host words into bytes. It fills the unused tail of the final sector with zeros and then emits the sector sum. Read comes in two forms, 0x02 and 0x12. Both pack stored bytes into host words and compare each sector's computed sum with the stored one. Check-write (0x05) compares host bytes with bytes read back. If the host falls behind the byte rate, the engine reports an overrun and stops at once. At every completed sector the engine pulses an increment strobe for the neighbouring address unit.

Top module: `sxe_sector_engine`

## Requirements
- R1: A `start` pulse is accepted only when all of these hold: the engine is idle, `order` is 0x01, 0x02, 0x05 or 0x12, and `word_count` is non-zero. When accepted, `busy` is high on the next cycle. A start with any other order, with a zero count, or while busy changes nothing. Whenever `busy` falls, `done` is high in that same cycle.
- R2: On write, each host word is sent bits 31:24 first, then 23:16, 15:8 and 7:0, one byte per tick. Data occupies sector positions 0 to SECT_BYTES-5.
- R3: On write, data positions after the last host byte of the record are written as 0x00.
- R4: The sector sum is the modulo-2^32 sum of the sector's data-area bytes, zero fill included. It is written in the last four positions, most significant byte first.
- R5: On read, the first byte of each group of four lands in bits 31:24 of the host word. Only `word_count` words are delivered. Bytes that follow the record in its final sector are read but not delivered.
- R6: On read with order 0x02, a sector whose computed sum differs from its stored sum does not stop the transfer. `xmit_err` is reported with `done` at the end of the record.
- R7: On read with order 0x12, the transfer ends with `done` and `xmit_err` at the end of the first failing sector.
- R8: On check-write, the first data byte that differs from the host byte (0x00 past the record) stops all further host word acceptance. The engine keeps reading to the end of that sector, then finishes with `xmit_err`. A stored sum that differs from the sum of the host bytes also gives `xmit_err`.
- R9: On write or check-write, the host has until the tick that needs the next word, four ticks after the previous word starts, to supply it. Otherwise `overrun` and `done` assert at once and no sector strobe is given.
- R10: On read, if a word completes while the previous word has not been taken, `overrun` and `done` assert at once and the pending word is dropped.
- R11: `sect_inc` pulses once for each completed sector. `done` follows the end of the sector in which the record's bytes ran out, so a record may span several sectors.
- R12: After reset `busy`, `done`, `sect_inc`, `hin_ready`, `hout_valid`, `st_wen`, `xmit_err` and `overrun` are all low.
- R13: A word offered on `hout_data` stays valid and unchanged until `hout_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a new order |
| order | input | 8 | Order code sampled with start |
| word_count | input | CNT_W | Record length in host words |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer ends |
| sect_inc | output | 1 | One-cycle pulse per completed sector |
| xmit_err | output | 1 | Transmission error result, valid from done until next start |
| overrun | output | 1 | Overrun result, valid from done until next start |
| hin_data | input | 32 | Host word to be stored or compared |
| hin_valid | input | 1 | Host word offered |
| hin_ready | output | 1 | Engine takes the offered host word |
| hout_data | output | 32 | Word read from storage |
| hout_valid | output | 1 | Read word offered to host |
| hout_ready | input | 1 | Host takes the read word |
| byte_tick | input | 1 | Storage byte time strobe |
| st_rdata | input | 8 | Byte read from storage at a tick |
| st_wdata | output | 8 | Byte to store at a tick |
| st_wen | output | 1 | Store st_wdata at this tick |

## Verification
Writes are run with record lengths that end exactly on a sector boundary, end inside one, and span several sectors. This separates the data path from the zero-fill and sum path, and shows whether the sector count is right. Ticks come either every cycle or in random gaps, so that pacing is shown not to change the stored image. Reads and check-writes replay images that are clean or have a flipped data or sum byte in a chosen sector. These tell the two read policies apart by where the transfer stops and how many words arrive. Stalled host patterns on either side provoke the overrun paths, while a throttled but still timely host checks that slow acceptance alone causes no error.

// File: rtl/sxe_pkg.sv
package sxe_pkg;

    localparam int SUM_BYTES = 4;

    typedef enum logic [7:0] {
        ORD_WRITE     = 8'h01,
        ORD_READ_REC  = 8'h02,
        ORD_CHECK     = 8'h05,
        ORD_READ_SECT = 8'h12
    } sxe_order_e;

    typedef struct packed {
        logic ok;
        logic wr;
        logic rd;
        logic cw;
        logic stop;
    } sxe_mode_t;

    function automatic sxe_mode_t decode_order(input logic [7:0] code);
        sxe_mode_t m;
        m = '0;
        case (code)
            ORD_WRITE:     begin m.ok = 1'b1; m.wr = 1'b1; end
            ORD_READ_REC:  begin m.ok = 1'b1; m.rd = 1'b1; end
            ORD_READ_SECT: begin m.ok = 1'b1; m.rd = 1'b1; m.stop = 1'b1; end
            ORD_CHECK:     begin m.ok = 1'b1; m.cw = 1'b1; end
            default:       m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] lane);
        return w[8*(3-lane) +: 8];
    endfunction

endpackage

// File: rtl/sxe_unpack.sv
module sxe_unpack
    import sxe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        accept,
    input  logic [31:0] word_in,
    input  logic        take,
    input  logic [1:0]  lane,
    output logic        hold_full,
    output logic [7:0]  exp_byte
);
    logic [31:0] hold_q;
    logic [31:0] act_q;
    logic        full_q;

    assign hold_full = full_q;
    assign exp_byte  = (lane == 2'd0) ? hold_q[31:24] : byte_of(act_q, lane);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            full_q <= 1'b0;
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (take) begin
                act_q  <= hold_q;
                full_q <= 1'b0;
            end
            if (accept) begin
                hold_q <= word_in;
                full_q <= 1'b1;
            end
        end
    end

    // R9
    no_refill_full_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> !full_q);

    // R9
    take_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> full_q);

endmodule

// File: rtl/sxe_pack.sv
module sxe_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        shift,
    input  logic        lane_last,
    input  logic [7:0]  byte_in,
    input  logic        hout_ready,
    output logic [31:0] hout_data,
    output logic        hout_valid,
    output logic        ovr
);
    logic [23:0] pk_q;
    logic [31:0] out_q;
    logic        vld_q;

    assign hout_data  = out_q;
    assign hout_valid = vld_q;
    assign ovr        = shift && lane_last && vld_q && !hout_ready;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld_q <= 1'b0;
            pk_q  <= '0;
            out_q <= '0;
        end else begin
            if (vld_q && hout_ready) vld_q <= 1'b0;
            if (shift) begin
                pk_q <= {pk_q[15:0], byte_in};
                if (lane_last && !ovr) begin
                    out_q <= {pk_q, byte_in};
                    vld_q <= 1'b1;
                end
            end
        end
    end

    // R13
    hout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !hout_ready && !clr) |=> (vld_q && $stable(out_q)));

endmodule

// File: rtl/sxe_sum.sv
module sxe_sum (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_en,
    input  logic        first,
    input  logic [7:0]  acc_byte,
    input  logic        cap_en,
    input  logic [7:0]  cap_byte,
    output logic [31:0] acc,
    output logic        sum_bad
);
    logic [31:0] acc_q;
    logic [31:0] stored_q;

    assign acc     = acc_q;
    assign sum_bad = acc_q != {stored_q[23:0], cap_byte};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            stored_q <= '0;
        end else begin
            if (acc_en) acc_q <= first ? {24'd0, acc_byte} : acc_q + {24'd0, acc_byte};
            if (cap_en) stored_q <= {stored_q[23:0], cap_byte};
        end
    end

    // R4
    sum_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_en) |=> $stable(acc_q));

endmodule

// File: rtl/sxe_sector_engine.sv
module sxe_sector_engine
    import sxe_pkg::*;
#(
    parameter int SECT_BYTES = 1024,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       order,
    input  logic [CNT_W-1:0] word_count,
    output logic             busy,
    output logic             done,
    output logic             sect_inc,
    output logic             xmit_err,
    output logic             overrun,
    input  logic [31:0]      hin_data,
    input  logic             hin_valid,
    output logic             hin_ready,
    output logic [31:0]      hout_data,
    output logic             hout_valid,
    input  logic             hout_ready,
    input  logic             byte_tick,
    input  logic [7:0]       st_rdata,
    output logic [7:0]       st_wdata,
    output logic             st_wen
);
    localparam int DATA_BYTES = SECT_BYTES - SUM_BYTES;
    localparam int POS_W      = $clog2(SECT_BYTES);
    localparam int LEFT_W     = CNT_W + 2;
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(SECT_BYTES - 1);
    localparam logic [POS_W-1:0] DATA_END  = POS_W'(DATA_BYTES);

    sxe_mode_t         mode_q, mode_d;
    logic              busy_q, done_q, sinc_q, xerr_q, ovr_q;
    logic              err_acc_q, cw_bad_q;
    logic [POS_W-1:0]  pos_q;
    logic [LEFT_W-1:0] bytes_left_q;
    logic [CNT_W-1:0]  fetch_left_q;

    logic       start_ok, tick, in_data, have_data, last_pos, data_tick;
    logic [1:0] lane;
    logic       host_side, use_host, take, ovr_host, ovr_pack, ovr_now;
    logic       hold_full, accept_word, cw_mis, pack_shift, cap_en;
    logic       sec_end, sec_err, sum_bad, finish;
    logic [7:0] exp_byte, host_byte, acc_byte;
    logic [31:0] acc;

    assign mode_d   = decode_order(order);
    assign start_ok = start && !busy_q && mode_d.ok && (word_count != '0);

    assign tick      = busy_q && byte_tick;
    assign in_data   = pos_q < DATA_END;
    assign have_data = bytes_left_q != '0;
    assign last_pos  = pos_q == LAST_POS;
    assign lane      = pos_q[1:0];
    assign data_tick = tick && in_data;

    assign host_side = mode_q.wr || mode_q.cw;
    assign use_host  = data_tick && have_data && host_side && !cw_bad_q;
    assign take      = use_host && (lane == 2'd0) && hold_full;
    assign ovr_host  = use_host && (lane == 2'd0) && !hold_full;
    assign host_byte = have_data ? exp_byte : 8'h00;
    assign acc_byte  = mode_q.rd ? st_rdata : host_byte;
    assign cw_mis    = data_tick && mode_q.cw && !cw_bad_q && (st_rdata != host_byte);
    assign pack_shift = data_tick && have_data && mode_q.rd;
    assign cap_en    = tick && !in_data && (mode_q.rd || mode_q.cw);
    assign ovr_now   = ovr_host || ovr_pack;

    assign sec_end = tick && last_pos;
    assign sec_err = (mode_q.rd || mode_q.cw) && (sum_bad || (mode_q.cw && cw_bad_q));
    assign finish  = ovr_now ||
                     (sec_end && (!have_data || (sec_err && (mode_q.cw || mode_q.stop))));

    assign hin_ready   = busy_q && host_side && !hold_full && (fetch_left_q != '0) && !cw_bad_q;
    assign accept_word = hin_valid && hin_ready;

    assign st_wdata = in_data ? host_byte : byte_of(acc, lane);
    assign st_wen   = tick && mode_q.wr && !ovr_host;

    assign busy     = busy_q;
    assign done     = done_q;
    assign sect_inc = sinc_q;
    assign xmit_err = xerr_q;
    assign overrun  = ovr_q;

    sxe_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .clr       (start_ok),
        .accept    (accept_word),
        .word_in   (hin_data),
        .take      (take),
        .lane      (lane),
        .hold_full (hold_full),
        .exp_byte  (exp_byte)
    );

    sxe_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .clr        (start_ok || ovr_now),
        .shift      (pack_shift),
        .lane_last  (lane == 2'd3),
        .byte_in    (st_rdata),
        .hout_ready (hout_ready),
        .hout_data  (hout_data),
        .hout_valid (hout_valid),
        .ovr        (ovr_pack)
    );

    sxe_sum u_sum (
        .clk      (clk),
        .rst      (rst),
        .acc_en   (data_tick),
        .first    (pos_q == '0),
        .acc_byte (acc_byte),
        .cap_en   (cap_en),
        .cap_byte (st_rdata),
        .acc      (acc),
        .sum_bad  (sum_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= '0;
            busy_q       <= 1'b0;
            done_q       <= 1'b0;
            sinc_q       <= 1'b0;
            xerr_q       <= 1'b0;
            ovr_q        <= 1'b0;
            err_acc_q    <= 1'b0;
            cw_bad_q     <= 1'b0;
            pos_q        <= '0;
            bytes_left_q <= '0;
            fetch_left_q <= '0;
        end else begin
            done_q <= finish;
            sinc_q <= sec_end;
            if (start_ok) begin
                mode_q       <= mode_d;
                busy_q       <= 1'b1;
                pos_q        <= '0;
                bytes_left_q <= {word_count, 2'b00};
                fetch_left_q <= word_count;
                err_acc_q    <= 1'b0;
                cw_bad_q     <= 1'b0;
                xerr_q       <= 1'b0;
                ovr_q        <= 1'b0;
            end else begin
                if (accept_word) fetch_left_q <= fetch_left_q - CNT_W'(1);
                if (tick) begin
                    pos_q <= last_pos ? '0 : pos_q + POS_W'(1);
                    if (in_data && have_data) bytes_left_q <= bytes_left_q - LEFT_W'(1);
                    if (cw_mis) cw_bad_q <= 1'b1;
                    if (sec_end) err_acc_q <= err_acc_q | sec_err;
                    if (finish) begin
                        busy_q <= 1'b0;
                        xerr_q <= err_acc_q | (sec_end & sec_err);
                        ovr_q  <= ovr_now;
                    end
                end
            end
        end
    end

    // R1
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q);

    // R1
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start) |=> $stable(mode_q));

    // R11
    sect_len_chk: assert property (@(posedge clk) disable iff (rst)
        sinc_q |-> ($past(pos_q) == LAST_POS));

    // R9
    ovr_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> (done_q && !busy_q));

    // R8
    cw_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (cw_bad_q && !start_ok) |=> $stable(fetch_left_q));

endmodule

// File: tb/sim_sxe_sector_engine.sv
`timescale 1ns/1ps
module sim_sxe_sector_engine;
    localparam int SB  = 32;
    localparam int D   = SB - 4;
    localparam int WPS = D / 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] order = 8'h00;
    logic [7:0] word_count = 8'd0;
    logic busy, done, sect_inc, xmit_err, overrun;
    logic [31:0] hin_data = '0;
    logic hin_valid = 1'b0;
    logic hin_ready;
    logic [31:0] hout_data;
    logic hout_valid;
    logic hout_ready = 1'b1;
    logic byte_tick = 1'b0;
    logic [7:0] st_rdata = '0;
    logic [7:0] st_wdata;
    logic st_wen;

    always #4 clk = ~clk;

    sxe_sector_engine #(.SECT_BYTES(SB), .CNT_W(8)) u0 (
        .clk(clk), .rst(rst), .start(start), .order(order), .word_count(word_count),
        .busy(busy), .done(done), .sect_inc(sect_inc), .xmit_err(xmit_err), .overrun(overrun),
        .hin_data(hin_data), .hin_valid(hin_valid), .hin_ready(hin_ready),
        .hout_data(hout_data), .hout_valid(hout_valid), .hout_ready(hout_ready),
        .byte_tick(byte_tick), .st_rdata(st_rdata), .st_wdata(st_wdata), .st_wen(st_wen)
    );

    int nerr = 0, nchk = 0, cyc = 0;
    bit fin = 0, active = 0;
    logic [7:0]  smem [256];
    logic [7:0]  wmem [256];
    logic [31:0] hw [64];
    logic [31:0] rw [64];
    int rcv, acc_cnt, scount;
    bit got_done, got_x, got_o;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nsect(input int n);
        return (n * 4 + D - 1) / D;
    endfunction

    task automatic build_image(input int n);
        for (int s = 0; s < nsect(n); s++) begin
            logic [31:0] sum;
            sum = 0;
            for (int p = 0; p < D; p++) begin
                int idx;
                logic [7:0] b;
                idx = s * D + p;
                b = (idx < n * 4) ? hw[idx / 4][8 * (3 - idx % 4) +: 8] : 8'h00;
                smem[s * SB + p] = b;
                sum = sum + {24'd0, b};
            end
            for (int k = 0; k < 4; k++) smem[s * SB + D + k] = sum[8 * (3 - k) +: 8];
        end
    endtask

    function automatic logic [31:0] exp_word(input int i);
        int b;
        b = (i / WPS) * SB + (i % WPS) * 4;
        return {smem[b], smem[b + 1], smem[b + 2], smem[b + 3]};
    endfunction

    task automatic host_tx(input int n, input int gap);
        int idx, gc;
        bit took;
        idx = 0; gc = 0; took = 0;
        while (active) begin
            @(negedge clk);
            if (took) begin idx++; took = 0; gc = gap; hin_valid = 1'b0; end
            if (!hin_valid && idx < n) begin
                if (gc == 0) begin hin_valid = 1'b1; hin_data = hw[idx]; end
                else gc--;
            end
            if (hin_valid && hin_ready) took = 1;
        end
        hin_valid = 1'b0;
        acc_cnt = idx + (took ? 1 : 0);
    endtask

    task automatic host_rx(input int rmode);
        rcv = 0;
        while (active || hout_valid) begin
            @(negedge clk);
            hout_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? ((cyc % 3) == 2) : 1'b0;
            if (hout_valid && hout_ready) begin rw[rcv] = hout_data; rcv++; end
            if (!active && rmode == 2) break;
        end
        hout_ready = 1'b1;
    endtask

    task automatic storage(input int tmode);
        int ptr;
        bit t;
        ptr = 0;
        repeat (3) @(negedge clk);
        while (active) begin
            @(negedge clk);
            t = (tmode == 0) ? 1'b1 : (($urandom % 4) != 0);
            byte_tick = t;
            st_rdata = smem[ptr];
            #1;
            if (t && busy) begin
                if (st_wen) wmem[ptr] = st_wdata;
                ptr++;
            end
        end
        byte_tick = 1'b0;
    endtask

    task automatic watch(input bit dbl);
        int it;
        it = 0;
        while (active) begin
            @(negedge clk);
            it++;
            if (dbl && it == 30) begin start = 1'b1; order = 8'h02; end
            if (dbl && it == 31) start = 1'b0;
            if (sect_inc) scount++;
            if (done) begin
                got_done = 1; got_x = xmit_err; got_o = overrun; active = 0;
            end
            if (it > 20000) begin
                chk(0, "watchdog run timeout", 0, 1);
                active = 0;
            end
        end
    endtask

    task automatic run(input logic [7:0] ord, input int n, input int tmode,
                       input int gap, input int rmode, input bit dbl);
        got_done = 0; got_x = 0; got_o = 0; scount = 0; rcv = 0; acc_cnt = 0;
        for (int i = 0; i < 256; i++) wmem[i] = 8'hEE;
        @(negedge clk);
        order = ord; word_count = 8'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        active = 1;
        fork
            host_tx(n, gap);
            host_rx(rmode);
            storage(tmode);
            watch(dbl);
        join
        repeat (2) @(negedge clk);
    endtask

    task automatic check_write_image(input int n, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < nsect(n) * SB; i++) if (wmem[i] !== smem[i]) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic check_read_words(input int nexp, input string tag);
        int bad;
        bad = 0;
        chk(rcv == nexp, {tag, " word count"}, rcv, nexp);
        for (int i = 0; i < nexp && i < rcv; i++) if (rw[i] !== exp_word(i)) bad++;
        chk(bad == 0, {tag, " word data"}, bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk({busy, done, sect_inc, hin_ready, hout_valid, st_wen, xmit_err, overrun} == 8'h00,
            "R12 reset outputs", {busy, done, sect_inc, hin_ready, hout_valid, st_wen, xmit_err, overrun}, 0);

        // R1 unsupported order and zero count are ignored
        order = 8'h03; word_count = 8'd5; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b0, "R1 bad order ignored", busy, 0);
        order = 8'h01; word_count = 8'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b0, "R1 zero count ignored", busy, 0);

        // R2 R4 R11 one full sector, ticks every cycle
        for (int i = 0; i < 64; i++) hw[i] = $urandom;
        build_image(WPS);
        run(8'h01, WPS, 0, 0, 0, 0);
        check_write_image(WPS, "R2 R4 full sector image");
        chk(scount == 1 && got_done, "R11 one sector strobe", scount, 1);

        // R3 zero fill in short record
        build_image(3);
        run(8'h01, 3, 1, 1, 0, 0);
        check_write_image(3, "R3 zero fill image");

        // R1 R11 start while busy ignored, record of two sectors
        build_image(10);
        run(8'h01, 10, 0, 0, 0, 1);
        check_write_image(10, "R1 busy start ignored image");
        chk(scount == 2, "R11 two sector strobes", scount, 2);

        // random records: write, check-write, read back
        for (int it = 0; it < 5; it++) begin
            int n;
            n = 1 + ($urandom % 20);
            for (int i = 0; i < 64; i++) hw[i] = $urandom;
            build_image(n);
            run(8'h01, n, 1, $urandom % 2, 0, 0);
            check_write_image(n, "R2 R4 random write image");
            chk(scount == nsect(n), "R11 random sector count", scount, nsect(n));
            run(8'h05, n, 1, 0, 0, 0);
            chk(got_done && !got_x && !got_o, "R8 clean check-write", {got_x, got_o}, 0);
            run(8'h12, n, 1, 0, 0, 0);
            check_read_words(n, "R5 random read");
            chk(!got_x && !got_o, "R5 clean read flags", {got_x, got_o}, 0);
        end

        // R6 record-end policy with error in sector 0
        for (int i = 0; i < 64; i++) hw[i] = $urandom;
        build_image(17);
        smem[3] = smem[3] ^ 8'h5A;
        run(8'h02, 17, 0, 0, 0, 0);
        check_read_words(17, "R6 read all sectors");
        chk(got_x == 1'b1, "R6 error at record end", got_x, 1);
        chk(scount == 3, "R6 sectors completed", scount, 3);

        // R7 stop at end of failing sector 1
        build_image(17);
        smem[SB + 3] = smem[SB + 3] ^ 8'h5A;
        run(8'h12, 17, 1, 0, 0, 0);
        check_read_words(2 * WPS, "R7 read stops");
        chk(got_x == 1'b1 && scount == 2, "R7 stop sector", {got_x, 8'(scount)}, {1'b1, 8'd2});

        // R8 check-write mismatch in sector 0
        build_image(10);
        hw[2] = hw[2] ^ 32'h00FF0000;
        run(8'h05, 10, 0, 0, 0, 0);
        chk(got_x == 1'b1 && scount == 1, "R8 mismatch ends at sector end", {got_x, 8'(scount)}, {1'b1, 8'd1});
        chk(acc_cnt <= 4, "R8 host fetch stopped", acc_cnt, 4);
        hw[2] = hw[2] ^ 32'h00FF0000;

        // R8 stored sum mismatch only
        build_image(4);
        smem[D] = smem[D] ^ 8'h01;
        run(8'h05, 4, 0, 0, 0, 0);
        chk(got_x == 1'b1, "R8 sum compare", got_x, 1);

        // R9 write overrun
        build_image(5);
        run(8'h01, 5, 0, 12, 0, 0);
        chk(got_o == 1'b1 && scount == 0 && got_done, "R9 write overrun", {got_o, 8'(scount)}, {1'b1, 8'd0});

        // R10 read overrun
        build_image(5);
        run(8'h02, 5, 0, 0, 2, 0);
        chk(got_o == 1'b1 && scount == 0, "R10 read overrun", {got_o, 8'(scount)}, {1'b1, 8'd0});

        // R13 throttled host still gets every word
        for (int i = 0; i < 64; i++) hw[i] = $urandom;
        build_image(12);
        run(8'h02, 12, 0, 0, 1, 0);
        check_read_words(12, "R13 throttled read");
        chk(!got_o, "R13 no overrun when throttled", got_o, 0);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule